// File: doc/BRIEF.md
# Saturating Fixed-Point ALU with Sticky Flags

This block is the integer adder stage of a signal-processing datapath. Each accepted operation takes two signed two's-complement operands and produces one registered result. The operation is one of add, subtract or halving average.

A mode input chooses between two ways of handling overflow:

- **Wrap-around:** the result rolls over modulo 2^DATA_W.
- **Clamping:** an overflowing result is replaced by the most positive or most negative representable value, whichever has the correct sign.

With every accepted operation, a five-bit status word is rewritten alongside the result. A two-bit accumulating flag register collects overflow and carry events over many operations. It holds them until the clear input is pulsed, so a whole block of samples can be processed and then checked once for trouble.

Top module: `fx_sat_alu`

## Requirements
- R1: After reset, `result`, `arithStat` and `stickyStat` are all zero.
- R2: `opCode` selects the operation: 00 is A+B, 01 is A−B, 10 is the average. When `opValid` is high at a rising edge, the result and status appear on the outputs after that same edge.
- R3: With `satMode` low, a signed overflow in add or subtract leaves the wrapped (modulo 2^DATA_W) result and sets the overflow bit.
- R4: The status bit positions are: bit0 zero, bit1 negative, bit2 overflow, bit3 carry, bit4 invalid. The zero and negative bits describe the stored result, after any clamping.
- R5: The invalid bit (bit4) is always 0.
- R6: With `satMode` high, a positive overflow stores 0x7FFFFFFF and a negative overflow stores 0x80000000. The overflow bit is still set in both cases.
- R7: The carry bit is set as follows:
  - for add, it is the unsigned carry out;
  - for subtract, it is 1 when A ≥ B unsigned (no borrow);
  - for the average, it is the low bit discarded by the halving.
- R8: The average is floor((A+B)/2), computed on a 33-bit signed sum. It never sets the overflow bit, and `satMode` has no effect on it.
- R9: `stickyStat` bit0 accumulates overflow and bit1 accumulates carry, using the flags of each accepted operation. Once a bit is set, it stays set.
- R10: `stickyClr` zeroes `stickyStat` at the next edge. It wins over a set from an operation in the same cycle, and it works without `opValid`.
- R11: When `opValid` is low, or when `opCode` is 11, `result`, `arithStat` and `stickyStat` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 2 | Operation select (00 add, 01 sub, 10 average, 11 none) |
| satMode | input | 1 | 1 = clamp on overflow, 0 = wrap |
| stickyClr | input | 1 | Clear the accumulated flags |
| opA | input | DATA_W | First signed operand |
| opB | input | DATA_W | Second signed operand |
| result | output | DATA_W | Registered result |
| arithStat | output | 5 | Status of the last accepted operation |
| stickyStat | output | 2 | Accumulated overflow (bit0) and carry (bit1) |

## Verification
The bench builds the block with the default DATA_W of 32. At that width the clamp values are 0x7FFFFFFF and 0x80000000, and operands at the signed extremes drive the sum across the sign boundary in both directions, for both add and subtract. The same extreme values also reach the average's sign-extended sum, where a truncated 32-bit sum would give the wrong answer. Accumulated-flag tests chain several operations and place clears both alone and in the same cycle as an operation.

// File: rtl/fx_alu_pkg.sv
package fx_alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_AVG  = 2'b10,
    OP_NONE = 2'b11
  } aluOp_e;

  // status word bit positions
  localparam int ST_ZERO  = 0;
  localparam int ST_NEG   = 1;
  localparam int ST_OVF   = 2;
  localparam int ST_CARRY = 3;
  localparam int ST_INV   = 4;
  localparam int ST_W     = 5;

  // accumulated flag positions
  localparam int SK_OVF   = 0;
  localparam int SK_CARRY = 1;
  localparam int SK_W     = 2;

  typedef struct packed {
    logic   load;    // capture result and status
    aluOp_e op;      // operation to perform
    logic   sat;     // clamp on overflow
    logic   stkClr;  // clear accumulated flags
    logic   stkSet;  // OR new flags into accumulated flags
  } aluCtl_t;

endpackage

// File: rtl/fx_alu_ctrl.sv
module fx_alu_ctrl
  import fx_alu_pkg::*;
(
  input  logic       opValid,
  input  logic [1:0] opCode,
  input  logic       satMode,
  input  logic       stickyClr,
  output aluCtl_t    ctl
);

  aluOp_e opDec;

  always_comb begin
    opDec      = aluOp_e'(opCode);
    ctl.op     = opDec;
    ctl.sat    = satMode;
    ctl.load   = opValid && (opDec != OP_NONE);
    ctl.stkClr = stickyClr;
    // a clear in the same cycle suppresses the set
    ctl.stkSet = opValid && (opDec != OP_NONE) && !stickyClr;
  end

endmodule

// File: rtl/fx_alu_dp.sv
module fx_alu_dp
  import fx_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluCtl_t           ctl,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] resQ,
  output logic [ST_W-1:0]   statQ,
  output logic [SK_W-1:0]   stkQ
);

  localparam int SUM_W = DATA_W + 1;
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MAX_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] bOp;
  logic [SUM_W-1:0]  uSum;
  logic [SUM_W-1:0]  sSum;
  logic [DATA_W-1:0] rawRes;
  logic [DATA_W-1:0] finRes;
  logic              carryN;
  logic              ovfN;
  logic              clampN;
  logic [ST_W-1:0]   statN;

  always_comb begin
    bOp  = (ctl.op == OP_SUB) ? ~b : b;
    uSum = {1'b0, a} + {1'b0, bOp} + {{DATA_W{1'b0}}, (ctl.op == OP_SUB)};
    sSum = {a[DATA_W-1], a} + {b[DATA_W-1], b};

    if (ctl.op == OP_AVG) begin
      rawRes = sSum[SUM_W-1:1];
      carryN = sSum[0];
      ovfN   = 1'b0;
    end else begin
      rawRes = uSum[DATA_W-1:0];
      carryN = uSum[DATA_W];
      ovfN   = (a[DATA_W-1] == bOp[DATA_W-1]) && (rawRes[DATA_W-1] != a[DATA_W-1]);
    end

    clampN = ctl.sat && ovfN;
    finRes = clampN ? (a[DATA_W-1] ? MAX_NEG : MAX_POS) : rawRes;

    statN           = '0;
    statN[ST_ZERO]  = (finRes == '0);
    statN[ST_NEG]   = finRes[DATA_W-1];
    statN[ST_OVF]   = ovfN;
    statN[ST_CARRY] = carryN;
    statN[ST_INV]   = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resQ  <= '0;
      statQ <= '0;
    end else if (ctl.load) begin
      resQ  <= finRes;
      statQ <= statN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stkQ <= '0;
    end else if (ctl.stkClr) begin
      stkQ <= '0;
    end else if (ctl.stkSet) begin
      stkQ[SK_OVF]   <= stkQ[SK_OVF] | ovfN;
      stkQ[SK_CARRY] <= stkQ[SK_CARRY] | carryN;
    end
  end

  // R5: invalid never raised for fixed-point work
  a_r5_invalid_zero: assert property (@(posedge clk) disable iff (!rstN)
    statQ[ST_INV] == 1'b0);

  // R6: clamped results sit at an extreme and still flag overflow
  a_r6_sat_bound: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.sat && ovfN) |=>
      ((resQ == MAX_POS) || (resQ == MAX_NEG)) && statQ[ST_OVF]);

  // R8: average never overflows
  a_r8_avg_no_ovf: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.op == OP_AVG) |=> !statQ[ST_OVF]);

  // R4: zero/negative describe the stored result
  a_r4_flags_match: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (statQ[ST_ZERO] == (resQ == '0)) && (statQ[ST_NEG] == resQ[DATA_W-1]));

  // R9: accumulated bits never drop without a clear
  a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.stkClr |=> ((stkQ & $past(stkQ)) == $past(stkQ)));

  // R10: clear empties the accumulated flags
  a_r10_clr_wins: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stkClr |=> (stkQ == '0));

  // R11: no accepted operation, no change
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> ($stable(resQ) && $stable(statQ)));

endmodule

// File: rtl/fx_sat_alu.sv
module fx_sat_alu
  import fx_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opCode,
  input  logic              satMode,
  input  logic              stickyClr,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic [ST_W-1:0]   arithStat,
  output logic [SK_W-1:0]   stickyStat
);

  aluCtl_t ctl;

  fx_alu_ctrl u_ctrl (
    .opValid   (opValid),
    .opCode    (opCode),
    .satMode   (satMode),
    .stickyClr (stickyClr),
    .ctl       (ctl)
  );

  fx_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .a     (opA),
    .b     (opB),
    .resQ  (result),
    .statQ (arithStat),
    .stkQ  (stickyStat)
  );

endmodule

// File: tb/fx_sat_alu_tb.sv
module fx_sat_alu_tb;

  localparam int CLK_P  = 10;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              opValid = 1'b0;
  logic [1:0]        opCode = 2'b00;
  logic              satMode = 1'b0;
  logic              stickyClr = 1'b0;
  logic [DATA_W-1:0] opA = '0;
  logic [DATA_W-1:0] opB = '0;
  logic [DATA_W-1:0] result;
  logic [4:0]        arithStat;
  logic [1:0]        stickyStat;

  int nChk = 0;
  int nBad = 0;
  logic [1:0] expStk = 2'b00;

  always #(CLK_P/2) clk = ~clk;

  fx_sat_alu #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .satMode(satMode), .stickyClr(stickyClr), .opA(opA), .opB(opB),
    .result(result), .arithStat(arithStat), .stickyStat(stickyStat)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one accepted (or offered) operation, then check at the following falling edge
  task automatic runOp(input string tag, input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic sat, input logic clr,
                       input logic [31:0] expRes, input logic [4:0] expStat);
    @(negedge clk);
    opA = a; opB = b; opCode = op; satMode = sat; opValid = 1'b1; stickyClr = clr;
    @(negedge clk);
    opValid = 1'b0; stickyClr = 1'b0;
    if (clr) expStk = 2'b00;
    else     expStk = expStk | {expStat[3], expStat[2]};
    chk({tag, " result"}, {32'h0, result}, {32'h0, expRes});
    chk({tag, " status"}, {59'h0, arithStat}, {59'h0, expStat});
    chk({tag, " sticky R9"}, {62'h0, stickyStat}, {62'h0, expStk});
  endtask

  task automatic tReset;
    chk("R1 result", {32'h0, result}, 64'h0);
    chk("R1 status", {59'h0, arithStat}, 64'h0);
    chk("R1 sticky", {62'h0, stickyStat}, 64'h0);
  endtask

  task automatic tAddBasic;
    runOp("R2 R7 add -1+1", 2'b00, 32'hFFFFFFFF, 32'h1, 1'b0, 1'b0, 32'h0, 5'b01001);
    runOp("R2 add 2+3", 2'b00, 32'h2, 32'h3, 1'b0, 1'b0, 32'h5, 5'b00000);
  endtask

  task automatic tWrap;
    runOp("R3 R4 add pos ovf wrap", 2'b00, 32'h7FFFFFFF, 32'h1, 1'b0, 1'b0, 32'h80000000, 5'b00110);
    runOp("R3 add neg ovf wrap", 2'b00, 32'h80000000, 32'hFFFFFFFF, 1'b0, 1'b0, 32'h7FFFFFFF, 5'b01100);
    runOp("R3 sub neg ovf wrap", 2'b01, 32'h80000000, 32'h1, 1'b0, 1'b0, 32'h7FFFFFFF, 5'b01100);
    runOp("R3 sub pos ovf wrap", 2'b01, 32'h7FFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0, 32'h80000000, 5'b00110);
  endtask

  task automatic tSat;
    runOp("R6 R4 add pos clamp", 2'b00, 32'h7FFFFFFF, 32'h1, 1'b1, 1'b0, 32'h7FFFFFFF, 5'b00100);
    runOp("R6 add neg clamp", 2'b00, 32'h80000000, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h80000000, 5'b01110);
    runOp("R6 sub neg clamp", 2'b01, 32'h80000000, 32'h1, 1'b1, 1'b0, 32'h80000000, 5'b01110);
    runOp("R6 sub pos clamp", 2'b01, 32'h7FFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h7FFFFFFF, 5'b00100);
    runOp("R6 no ovf unchanged", 2'b00, 32'h10, 32'h20, 1'b1, 1'b0, 32'h30, 5'b00000);
  endtask

  task automatic tSub;
    runOp("R7 sub no borrow", 2'b01, 32'h5, 32'h3, 1'b0, 1'b0, 32'h2, 5'b01000);
    runOp("R7 sub borrow", 2'b01, 32'h3, 32'h5, 1'b0, 1'b0, 32'hFFFFFFFE, 5'b00010);
    runOp("R4 sub equal zero", 2'b01, 32'h1234, 32'h1234, 1'b0, 1'b0, 32'h0, 5'b01001);
  endtask

  task automatic tAvg;
    runOp("R8 avg max+max", 2'b10, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1, 1'b0, 32'h7FFFFFFF, 5'b00000);
    runOp("R8 avg min+min", 2'b10, 32'h80000000, 32'h80000000, 1'b0, 1'b0, 32'h80000000, 5'b00010);
    runOp("R8 R7 avg -1+0 floor", 2'b10, 32'hFFFFFFFF, 32'h0, 1'b0, 1'b0, 32'hFFFFFFFF, 5'b01010);
    runOp("R8 avg -1+1", 2'b10, 32'hFFFFFFFF, 32'h1, 1'b0, 1'b0, 32'h0, 5'b00001);
    runOp("R7 avg 3+4 odd", 2'b10, 32'h3, 32'h4, 1'b0, 1'b0, 32'h3, 5'b01000);
  endtask

  task automatic tIgnore;
    logic [31:0] r0;
    logic [4:0]  s0;
    logic [1:0]  k0;
    r0 = result; s0 = arithStat; k0 = stickyStat;
    @(negedge clk);
    opA = 32'h7FFFFFFF; opB = 32'h7FFFFFFF; opCode = 2'b00; opValid = 1'b0;
    @(negedge clk);
    chk("R11 no valid result", {32'h0, result}, {32'h0, r0});
    chk("R11 no valid status", {59'h0, arithStat}, {59'h0, s0});
    opCode = 2'b11; opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    chk("R11 code 11 result", {32'h0, result}, {32'h0, r0});
    chk("R11 code 11 status", {59'h0, arithStat}, {59'h0, s0});
    chk("R11 code 11 sticky", {62'h0, stickyStat}, {62'h0, k0});
  endtask

  task automatic tSticky;
    // clear alone, no operation
    @(negedge clk);
    stickyClr = 1'b1;
    @(negedge clk);
    stickyClr = 1'b0;
    expStk = 2'b00;
    chk("R10 clear alone", {62'h0, stickyStat}, 64'h0);
    runOp("R9 set carry", 2'b00, 32'hFFFFFFFF, 32'h1, 1'b0, 1'b0, 32'h0, 5'b01001);
    runOp("R9 set ovf", 2'b00, 32'h7FFFFFFF, 32'h1, 1'b0, 1'b0, 32'h80000000, 5'b00110);
    runOp("R9 quiet op keeps", 2'b00, 32'h1, 32'h1, 1'b0, 1'b0, 32'h2, 5'b00000);
    chk("R9 both held", {62'h0, stickyStat}, 64'h3);
    // clear together with an overflowing operation: clear wins, status updates
    runOp("R10 clear beats set", 2'b00, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b1, 32'hFFFFFFFE, 5'b00110);
  endtask

  initial begin
    #(CLK_P * 100000);
    nChk++; nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tAddBasic();
    tWrap();
    tSat();
    tSub();
    tAvg();
    tIgnore();
    tSticky();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule